// File: doc/BRIEF.md
# Dual-Width Byte-Lane Static Memory

This block is a synthesizable model of an asynchronous static memory. Its data bus runs either as a 16-bit word bus or as an 8-bit byte bus. Two chip selects gate every access: one is active low and one is active high. Separate enables for writing and for output control reads and writes. Two active-low lane enables pick the lower and upper byte lanes. A mode input chooses between word and byte width. In byte mode the most significant data pin stops carrying data and becomes the least significant address bit, below the word address.

The shared bus is split into an input vector, an output vector and a per-bit output-enable vector, so an I/O pad or an on-chip bus can form the tri-state net. The enables are decoded per lane. Stores are held in one register array per lane. A write window opens only when every write condition holds for a lane. It closes as soon as any one of them drops. The array is updated when the window closes, using the address and data present in the last clock cycle of the window. A byte-mode access that does not hold both lane enables low is refused and reported on an error output.

Top module: `duallane_sram`

## Requirements
- R1: When `csel_n` is high or `csel` is low, every bit of `dq_oe` is 0, no lane of the array is written, and `proto_err` is 0.
- R2: In word mode (`word_mode`=1) with both `lo_en_n` and `hi_en_n` high, `dq_oe` is all zero and nothing is written.
- R3: In word mode, a write changes only the lanes whose enable is low: `lo_en_n` covers data bits 7:0 and `hi_en_n` covers bits 15:8. A lane whose enable is high keeps its previous contents.
- R4: In word mode, a lane drives stored data, with its eight `dq_oe` bits set, exactly when the chip is selected, `wr_n` is high, `out_en_n` is low and that lane's enable is low.
- R5: With `wr_n` high and `out_en_n` high, no bit is driven even when the chip and its lanes are selected.
- R6: A write takes place whatever the level of `out_en_n`, and while `wr_n` is low no bit of `dq_oe` is set.
- R7: In byte mode (`word_mode`=0) with both lane enables low, the byte address is {`addr`, `dq_in[15]`}. `dq_in[15]`=0 selects bits 7:0 of the stored word and 1 selects bits 15:8. Write data enters on `dq_in[7:0]` and read data leaves on `dq_out[7:0]`.
- R8: In byte mode, `dq_oe[15:8]` is always 0.
- R9: A selected byte-mode access with either lane enable high sets `proto_err` to 1. The access is suppressed: nothing is driven and nothing is written.
- R10: The array is updated at the first clock edge after a lane's write window closes. The value stored is the address and data sampled at the last clock edge while the window was open, so data changed during the window replaces earlier data.
- R11: A window closes when any of its conditions drops: `csel_n` rising, `csel` falling, `wr_n` rising, or the lane's enable rising. Each lane closes on its own, so one lane can commit while the other stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for write windows |
| rst_n | input | 1 | Asynchronous active-low reset of the window state |
| csel_n | input | 1 | Active-low chip select |
| csel | input | 1 | Active-high chip select |
| wr_n | input | 1 | Active-low write enable |
| out_en_n | input | 1 | Active-low output enable |
| lo_en_n | input | 1 | Active-low lower lane enable |
| hi_en_n | input | 1 | Active-low upper lane enable |
| word_mode | input | 1 | 1 selects the 16-bit bus, 0 selects the 8-bit bus |
| addr | input | ADDR_W | Word address |
| dq_in | input | 2*LANE_W | Bus input; the top bit is the extra address bit in byte mode |
| dq_out | output | 2*LANE_W | Bus output value, 0 where not driven |
| dq_oe | output | 2*LANE_W | Per-bit drive enable for the tri-state bus |
| proto_err | output | 1 | Byte-mode access refused because a lane enable is high |

## Verification
The bench builds the block with ADDR_W=4 and LANE_W=8, which gives sixteen words of two byte lanes. With this size the byte-address bit sits on bit 15 and the dead bits 14:8 are observable. The small depth lets directed tests keep separate addresses for each scenario. With these values the bench can reach these cases:
- a window whose data changes over three cycles;
- a window closed by a chip select rather than by the write enable;
- one lane closing while the other stays open.

The bench also checks how word reads of words assembled in byte mode line up with the lanes.

// File: rtl/dls_pkg.sv
package dls_pkg;

   localparam int LANES = 2;

   typedef logic [LANES-1:0] lane_vec_t;

   typedef enum logic {
      BUS_BYTE = 1'b0,
      BUS_WORD = 1'b1
   } bus_mode_e;

   typedef struct packed {
      logic      sel;
      bus_mode_e mode;
      logic      err;
      lane_vec_t rd;
      lane_vec_t wr;
   } dls_ctl_t;

   // Lane activated by a full-width byte access: the extra address bit picks it.
   function automatic lane_vec_t byte_lane(input logic a_low);
      lane_vec_t v;
      v = '0;
      v[a_low] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/dls_decode.sv
module dls_decode
   import dls_pkg::*;
(
   input  logic     csel_n,
   input  logic     csel,
   input  logic     wr_n,
   input  logic     out_en_n,
   input  logic     lo_en_n,
   input  logic     hi_en_n,
   input  logic     word_mode,
   input  logic     a_low,
   output dls_ctl_t ctl
);

   lane_vec_t lane_req;
   lane_vec_t lane_act;
   logic      both_req;
   logic      selected;
   bus_mode_e mode;

   always_comb begin
      selected = ~csel_n & csel;
      mode     = bus_mode_e'(word_mode);
      lane_req = {~hi_en_n, ~lo_en_n};
      both_req = &lane_req;

      if (mode == BUS_WORD) begin
         lane_act = lane_req;
      end else if (both_req) begin
         lane_act = byte_lane(a_low);
      end else begin
         lane_act = '0;
      end

      ctl.sel  = selected;
      ctl.mode = mode;
      ctl.err  = selected & (mode == BUS_BYTE) & ~both_req;
      ctl.wr   = (selected & ~wr_n) ? lane_act : '0;
      ctl.rd   = (selected & wr_n & ~out_en_n) ? lane_act : '0;
   end

endmodule

// File: rtl/dls_wwin.sv
module dls_wwin #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_now,
   input  logic [ADDR_W-1:0] addr_now,
   input  logic [LANE_W-1:0] data_now,
   output logic              commit,
   output logic [ADDR_W-1:0] cmt_addr,
   output logic [LANE_W-1:0] cmt_data
);

   logic              open_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LANE_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         open_q <= open_now;
         if (open_now) begin
            addr_q <= addr_now;
            data_q <= data_now;
         end
      end
   end

   assign commit   = open_q & ~open_now;
   assign cmt_addr = addr_q;
   assign cmt_data = data_q;

endmodule

// File: rtl/dls_lane_mem.sv
module dls_lane_mem #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANE_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         cells[waddr] <= wdata;
      end
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/duallane_sram.sv
module duallane_sram
   import dls_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  csel_n,
   input  logic                  csel,
   input  logic                  wr_n,
   input  logic                  out_en_n,
   input  logic                  lo_en_n,
   input  logic                  hi_en_n,
   input  logic                  word_mode,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [2*LANE_W-1:0]   dq_in,
   output logic [2*LANE_W-1:0]   dq_out,
   output logic [2*LANE_W-1:0]   dq_oe,
   output logic                  proto_err
);

   localparam int DQ_W = LANES * LANE_W;

   generate
      if (LANE_W < 1) begin : g_bad_lane
         $error("duallane_sram: LANE_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("duallane_sram: ADDR_W must lie in 1..12");
      end
   endgenerate

   logic     a_low;
   dls_ctl_t ctl;

   assign a_low = dq_in[DQ_W-1];

   dls_decode dec_i (
      .csel_n   (csel_n),
      .csel     (csel),
      .wr_n     (wr_n),
      .out_en_n (out_en_n),
      .lo_en_n  (lo_en_n),
      .hi_en_n  (hi_en_n),
      .word_mode(word_mode),
      .a_low    (a_low),
      .ctl      (ctl)
   );

   logic [LANE_W-1:0] lane_rd [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] din;
      logic              commit;
      logic [ADDR_W-1:0] cmt_addr;
      logic [LANE_W-1:0] cmt_data;

      // Byte mode feeds every lane from the low bits of the bus.
      assign din = (ctl.mode == BUS_WORD) ? dq_in[g*LANE_W +: LANE_W]
                                          : dq_in[LANE_W-1:0];

      dls_wwin #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) win_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .open_now(ctl.wr[g]),
         .addr_now(addr),
         .data_now(din),
         .commit  (commit),
         .cmt_addr(cmt_addr),
         .cmt_data(cmt_data)
      );

      dls_lane_mem #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) mem_i (
         .clk  (clk),
         .we   (commit),
         .waddr(cmt_addr),
         .wdata(cmt_data),
         .raddr(addr),
         .rdata(lane_rd[g])
      );
   end

   always_comb begin
      dq_out = '0;
      dq_oe  = '0;
      if (ctl.mode == BUS_WORD) begin
         for (int k = 0; k < LANES; k++) begin
            if (ctl.rd[k]) begin
               dq_out[k*LANE_W +: LANE_W] = lane_rd[k];
               dq_oe [k*LANE_W +: LANE_W] = '1;
            end
         end
      end else if (|ctl.rd) begin
         dq_out[LANE_W-1:0] = ctl.rd[1] ? lane_rd[1] : lane_rd[0];
         dq_oe [LANE_W-1:0] = '1;
      end
   end

   assign proto_err = ctl.err;

endmodule

// File: rtl/duallane_sram_chk.sv
module duallane_sram_chk #(
   parameter int LANE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                csel_n,
   input logic                csel,
   input logic                wr_n,
   input logic                out_en_n,
   input logic                lo_en_n,
   input logic                hi_en_n,
   input logic                word_mode,
   input logic [2*LANE_W-1:0] dq_oe,
   input logic                proto_err
);

   p_desel_float_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (csel_n || !csel) |-> (dq_oe == '0 && !proto_err));

   p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (word_mode && lo_en_n && hi_en_n) |-> (dq_oe == '0));

   p_lane_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (word_mode && !csel_n && csel && wr_n && !out_en_n && !lo_en_n)
         |-> (&dq_oe[LANE_W-1:0]));

   p_out_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> (dq_oe == '0));

   p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> (dq_oe == '0));

   p_byte_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !word_mode |-> (dq_oe[2*LANE_W-1:LANE_W] == '0));

   p_err_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> (dq_oe == '0 && !word_mode));

endmodule

bind duallane_sram duallane_sram_chk #(.LANE_W(LANE_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .csel_n   (csel_n),
   .csel     (csel),
   .wr_n     (wr_n),
   .out_en_n (out_en_n),
   .lo_en_n  (lo_en_n),
   .hi_en_n  (hi_en_n),
   .word_mode(word_mode),
   .dq_oe    (dq_oe),
   .proto_err(proto_err)
);

// File: tb/duallane_sram_tb_top.sv
module duallane_sram_tb_top;

   localparam int AW = 4;
   localparam int LW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          csel_n, csel, wr_n, out_en_n, lo_en_n, hi_en_n, word_mode;
   logic [AW-1:0] addr;
   logic [15:0]   dq_in;
   logic [15:0]   dq_out;
   logic [15:0]   dq_oe;
   logic          proto_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   duallane_sram #(.ADDR_W(AW), .LANE_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .csel(csel), .wr_n(wr_n),
      .out_en_n(out_en_n), .lo_en_n(lo_en_n), .hi_en_n(hi_en_n),
      .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe), .proto_err(proto_err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      csel_n = 1'b1; csel = 1'b0; wr_n = 1'b1; out_en_n = 1'b1;
      lo_en_n = 1'b1; hi_en_n = 1'b1; word_mode = 1'b1; addr = '0; dq_in = '0;
   endtask

   task automatic wr_word(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic lo_n, input logic hi_n);
      @(negedge clk);
      csel_n = 1'b0; csel = 1'b1; word_mode = 1'b1; addr = a; dq_in = d;
      lo_en_n = lo_n; hi_en_n = hi_n; out_en_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1; out_en_n = 1'b1;
      @(negedge clk);
      idle();
   endtask

   task automatic rd_word(input logic [AW-1:0] a, input logic lo_n, input logic hi_n,
                          output logic [15:0] d, output logic [15:0] oe);
      @(negedge clk);
      csel_n = 1'b0; csel = 1'b1; word_mode = 1'b1; addr = a; dq_in = '0;
      lo_en_n = lo_n; hi_en_n = hi_n; out_en_n = 1'b0; wr_n = 1'b1;
      #1;
      d = dq_out; oe = dq_oe;
   endtask

   task automatic wr_byte(input logic [AW-1:0] a, input logic am1, input logic [7:0] d);
      @(negedge clk);
      csel_n = 1'b0; csel = 1'b1; word_mode = 1'b0; addr = a;
      dq_in = {am1, 7'h00, d}; lo_en_n = 1'b0; hi_en_n = 1'b0; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      #1;
      check("R1 reset oe", 32'(dq_oe), 32'h0);
      check("R1 reset proto_err", 32'(proto_err), 32'h0);
   endtask

   task automatic t_word_lanes();
      logic [15:0] d, oe;
      // R6: the write with out_en_n low must still store and not drive
      @(negedge clk);
      csel_n = 1'b0; csel = 1'b1; word_mode = 1'b1; addr = 4'd3; dq_in = 16'hA55A;
      lo_en_n = 1'b0; hi_en_n = 1'b0; out_en_n = 1'b0; wr_n = 1'b0;
      #1 check("R6 no drive while writing", 32'(dq_oe), 32'h0);
      @(negedge clk); wr_n = 1'b1; out_en_n = 1'b1;
      @(negedge clk); idle();
      rd_word(4'd3, 1'b0, 1'b0, d, oe);
      check("R6 write with output enable low stored", 32'(d), 32'hA55A);
      check("R4 word read oe", 32'(oe), 32'hFFFF);
      wr_word(4'd3, 16'h77FF, 1'b1, 1'b0);
      rd_word(4'd3, 1'b0, 1'b0, d, oe);
      check("R3 upper-only write", 32'(d), 32'h775A);
      rd_word(4'd3, 1'b0, 1'b1, d, oe);
      check("R4 lower-lane read oe", 32'(oe), 32'h00FF);
      check("R4 lower-lane read data", 32'(d), 32'h005A);
      rd_word(4'd3, 1'b1, 1'b0, d, oe);
      check("R4 upper-lane read", 32'({oe, d}), 32'hFF007700);
   endtask

   task automatic t_float_cases();
      logic [15:0] d, oe;
      rd_word(4'd3, 1'b1, 1'b1, d, oe);
      check("R2 standby floats", 32'(oe), 32'h0);
      @(negedge clk); out_en_n = 1'b1; lo_en_n = 1'b0; hi_en_n = 1'b0;
      #1 check("R5 output disable floats", 32'(dq_oe), 32'h0);
      // R2: write attempt in standby leaves data
      wr_word(4'd3, 16'h0000, 1'b1, 1'b1);
      // R1: write with csel low is ignored
      @(negedge clk);
      csel_n = 1'b0; csel = 1'b0; addr = 4'd3; dq_in = 16'hFFFF;
      lo_en_n = 1'b0; hi_en_n = 1'b0; out_en_n = 1'b0; wr_n = 1'b0;
      #1 check("R1 deselected floats", 32'({15'd0, proto_err, dq_oe}), 32'h0);
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); csel_n = 1'b1; csel = 1'b1; wr_n = 1'b0;
      @(negedge clk); idle();
      rd_word(4'd3, 1'b0, 1'b0, d, oe);
      check("R1 R2 ignored writes leave word", 32'(d), 32'h775A);
   endtask

   task automatic t_byte_mode();
      logic [15:0] d, oe;
      wr_byte(4'd5, 1'b0, 8'h3C);
      wr_byte(4'd5, 1'b1, 8'hC3);
      rd_word(4'd5, 1'b0, 1'b0, d, oe);
      check("R7 byte writes assemble word", 32'(d), 32'hC33C);
      @(negedge clk);
      word_mode = 1'b0; addr = 4'd5; dq_in = 16'h8000; lo_en_n = 1'b0; hi_en_n = 1'b0;
      #1;
      check("R7 byte read high", 32'(dq_out), 32'h00C3);
      check("R8 byte read oe", 32'(dq_oe), 32'h00FF);
      dq_in = 16'h0000;
      #1 check("R7 byte read low", 32'(dq_out), 32'h003C);
      // R9: refused byte write
      @(negedge clk);
      addr = 4'd3; dq_in = 16'h0011; hi_en_n = 1'b1; wr_n = 1'b0;
      #1 check("R9 proto_err on write", 32'({proto_err, dq_oe}), 32'h10000);
      @(negedge clk); wr_n = 1'b1; out_en_n = 1'b0;
      #1 check("R9 proto_err on read floats", 32'({proto_err, dq_oe}), 32'h10000);
      @(negedge clk); idle();
      rd_word(4'd3, 1'b0, 1'b0, d, oe);
      check("R9 refused write suppressed", 32'(d), 32'h775A);
   endtask

   task automatic t_windows();
      logic [15:0] d, oe;
      @(negedge clk);
      csel_n = 1'b0; csel = 1'b1; word_mode = 1'b1; addr = 4'd7;
      lo_en_n = 1'b0; hi_en_n = 1'b0; wr_n = 1'b0; dq_in = 16'hAAAA;
      @(negedge clk); dq_in = 16'h5555;
      @(negedge clk); dq_in = 16'h1234;
      @(negedge clk); wr_n = 1'b1; dq_in = 16'hDEAD;
      @(negedge clk); idle();
      rd_word(4'd7, 1'b0, 1'b0, d, oe);
      check("R10 last data in window stored", 32'(d), 32'h1234);
      // R11: closed by chip select, wr_n held low
      @(negedge clk);
      csel_n = 1'b0; csel = 1'b1; addr = 4'd8; lo_en_n = 1'b0; hi_en_n = 1'b0;
      wr_n = 1'b0; dq_in = 16'hBEEF;
      @(negedge clk); csel_n = 1'b1; dq_in = 16'h0000;
      @(negedge clk); idle();
      rd_word(4'd8, 1'b0, 1'b0, d, oe);
      check("R11 window closed by select", 32'(d), 32'hBEEF);
      // R11: upper lane closes first, lower keeps going
      @(negedge clk);
      csel_n = 1'b0; csel = 1'b1; addr = 4'd9; lo_en_n = 1'b0; hi_en_n = 1'b0;
      wr_n = 1'b0; dq_in = 16'h2222;
      @(negedge clk); hi_en_n = 1'b1; dq_in = 16'h3333;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); idle();
      rd_word(4'd9, 1'b0, 1'b0, d, oe);
      check("R11 per-lane window close", 32'(d), 32'h2233);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_word_lanes();
      t_float_cases();
      t_byte_mode();
      t_windows();
      @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule